// File: doc/BRIEF.md
# Mains-Tick Time-of-Day Clock

This block keeps a 24-hour time of day from a 60 Hz mains-derived tick. The tick reaches the block as a one-cycle enable pulse in the system clock domain. A divide-by-sixty prescaler turns those pulses into one enable per second. That enable steps a chain of BCD digit counters for seconds, minutes and hours. Each stage hands its wrap pulse to the next stage in the same clock cycle.

For setting the clock, a fast-advance input routes every raw tick straight into the seconds units digit and skips the prescaler. Time then runs sixty times faster, so an operator can reach any time of day within one real day of ticks at most. While fast-advance is held, the prescaler is kept at zero. After release, the first normal second therefore takes a full sixty ticks. The six BCD digits are register outputs that feed display decoding elsewhere.

Top module: `tod_clock`

## Requirements
- R1: While `rst` is high at a clock edge, all six digits go to zero (00:00:00) and the prescaler count is cleared, so that sixty further ticks are needed for the first second.
- R2: With `fast_set` low, the seconds advance by one on the clock edge that samples the sixtieth `tick` pulse counted since the last advance, and not on any earlier pulse.
- R3: In a cycle where `tick` is low, no digit changes on the following edge, whatever the level of `fast_set`.
- R4: Seconds units count 0 to 9 and wrap to 0 while incrementing the seconds tens. Seconds tens count 0 to 5, and 59 seconds rolls over to 00 with a carry into the minutes.
- R5: Minutes count 00 to 59 in the same two-digit way, and 59 minutes rolls over to 00 with a carry into the hours. The carry takes effect on the same edge as the seconds rollover.
- R6: Hours count 00 to 23, with the units carrying into the tens after 9. On the step after 23:59:59 the time becomes 00:00:00.
- R7: While `fast_set` is high, every `tick` pulse advances the seconds by exactly one on the edge that samples it.
- R8: While `fast_set` is high, the prescaler is held at zero, even in cycles without a tick. After release, the next second needs sixty ticks.
- R9: Every digit port carries its decimal value as unsigned binary in bits [3:0]. The hours tens never exceeds 2, and no other tens digit exceeds 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to 00:00:00 |
| tick | input | 1 | One-cycle 60 Hz time-base pulse |
| fast_set | input | 1 | High: every tick advances the seconds directly |
| hr_tens | output | 4 | Hours tens digit, BCD 0..2 |
| hr_ones | output | 4 | Hours units digit, BCD 0..9 |
| min_tens | output | 4 | Minutes tens digit, BCD 0..5 |
| min_ones | output | 4 | Minutes units digit, BCD 0..9 |
| sec_tens | output | 4 | Seconds tens digit, BCD 0..5 |
| sec_ones | output | 4 | Seconds units digit, BCD 0..9 |

## Verification
The assertions check the following on every cycle:
- every digit stays inside its legal BCD range;
- nothing moves in a cycle without a tick;
- each fast-advance tick changes the seconds units;
- reset clears all digits;
- the 23:59:59 rollover returns to midnight.

Two behaviours depend on the hidden prescaler count and are shown only by the bench's scenarios. The first is that exactly sixty normal ticks make one second. The second is that fast-advance leaves the prescaler empty on release. The same holds for the carry ripple through every digit boundary (9 to 10, 59 to 00, 09 to 10 hours, 19 to 20 hours), which the bench drives one scenario at a time.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int TICKS_PER_SEC = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic bypass,
  output logic sec_en
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || bypass) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    if (bypass) sec_en = tick;
    else        sec_en = tick && (cnt == LAST);
  end
endmodule

// File: rtl/tod_digit.sv
module tod_digit
  import tod_pkg::*;
#(
  parameter int MODULUS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output bcd_t q,
  output logic wrap
);
  localparam bcd_t LAST = bcd_t'(MODULUS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= (q == LAST) ? '0 : q + bcd_t'(1);
    end
  end

  assign wrap = en && (q == LAST);
endmodule

// File: rtl/tod_base60.sv
module tod_base60
  import tod_pkg::*;
#(
  parameter int UNITS_MOD = 10,
  parameter int TENS_MOD  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output bcd_t units,
  output bcd_t tens,
  output logic carry
);
  logic units_wrap;

  tod_digit #(.MODULUS(UNITS_MOD)) u_units (
    .clk(clk), .rst(rst), .en(en), .q(units), .wrap(units_wrap)
  );

  tod_digit #(.MODULUS(TENS_MOD)) u_tens (
    .clk(clk), .rst(rst), .en(units_wrap), .q(tens), .wrap(carry)
  );
endmodule

// File: rtl/tod_hours.sv
module tod_hours
  import tod_pkg::*;
#(
  parameter int HOURS_PER_DAY = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output bcd_t tens,
  output bcd_t ones
);
  localparam bcd_t TENS_LAST = bcd_t'((HOURS_PER_DAY - 1) / 10);
  localparam bcd_t ONES_LAST = bcd_t'((HOURS_PER_DAY - 1) % 10);
  localparam bcd_t NINE      = bcd_t'(9);

  always_ff @(posedge clk) begin
    if (rst) begin
      tens <= '0;
      ones <= '0;
    end else if (en) begin
      if (tens == TENS_LAST && ones == ONES_LAST) begin
        tens <= '0;
        ones <= '0;
      end else if (ones == NINE) begin
        ones <= '0;
        tens <= tens + bcd_t'(1);
      end else begin
        ones <= ones + bcd_t'(1);
      end
    end
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int TICKS_PER_SEC = 60,
  parameter int HOURS_PER_DAY = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       fast_set,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] min_tens,
  output logic [3:0] min_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_ones
);
  localparam int N_STAGES = 2;

  logic              stage_en [N_STAGES+1];
  bcd_t              st_units [N_STAGES];
  bcd_t              st_tens  [N_STAGES];
  logic              sec_en;

  tod_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .tick(tick), .bypass(fast_set), .sec_en(sec_en)
  );

  assign stage_en[0] = sec_en;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_b60
    tod_base60 #(.UNITS_MOD(10), .TENS_MOD(6)) u_stage (
      .clk(clk), .rst(rst), .en(stage_en[g]),
      .units(st_units[g]), .tens(st_tens[g]), .carry(stage_en[g+1])
    );
  end

  bcd_t h_t, h_o;

  tod_hours #(.HOURS_PER_DAY(HOURS_PER_DAY)) u_hours (
    .clk(clk), .rst(rst), .en(stage_en[N_STAGES]), .tens(h_t), .ones(h_o)
  );

  assign sec_ones = st_units[0];
  assign sec_tens = st_tens[0];
  assign min_ones = st_units[1];
  assign min_tens = st_tens[1];
  assign hr_ones  = h_o;
  assign hr_tens  = h_t;
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       fast_set,
  input logic [3:0] hr_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_ones
);
  logic [23:0] hms;
  assign hms = {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (hms == 24'h0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(hms));

  // R4
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_ones <= 4'd9) && (sec_tens <= 4'd5));

  // R5
  min_range_chk: assert property (@(posedge clk) disable iff (rst)
    (min_ones <= 4'd9) && (min_tens <= 4'd5));

  // R9
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_tens <= 4'd2) && (hr_ones <= 4'd9) && !(hr_tens == 4'd2 && hr_ones > 4'd3));

  // R7
  fast_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_set && tick) |=> (sec_ones != $past(sec_ones)));

  // R6
  midnight_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_set && tick && hms == 24'h235959) |=> (hms == 24'h0));
endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .fast_set(fast_set),
  .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens),
  .min_ones(min_ones), .sec_tens(sec_tens), .sec_ones(sec_ones)
);

// File: tb/test_tod_clock.sv
`timescale 1ns/1ps
module test_tod_clock;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic fast_set = 1'b0;
  logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;

  always #2.5 clk = ~clk;

  tod_clock i_tod_clock (
    .clk(clk), .rst(rst), .tick(tick), .fast_set(fast_set),
    .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens),
    .min_ones(min_ones), .sec_tens(sec_tens), .sec_ones(sec_ones)
  );

  typedef struct {
    logic [23:0] hms;
    string       req;
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  int secs = 0;
  int pre  = 0;
  bit done = 0;

  function automatic logic [23:0] to_bcd(int s);
    int h, m, x;
    h = s / 3600; m = (s / 60) % 60; x = s % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(x / 10), 4'(x % 10)};
  endfunction

  function automatic void model_step(bit fast);
    if (fast) begin
      pre  = 0;
      secs = (secs + 1) % 86400;
    end else begin
      pre = pre + 1;
      if (pre == 60) begin
        pre  = 0;
        secs = (secs + 1) % 86400;
      end
    end
  endfunction

  task automatic expect_now(string req);
    item_t it;
    it.hms = to_bcd(secs);
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic run(int n, bit fast, string req);
    @(negedge clk);
    tick = 1'b1; fast_set = fast;
    repeat (n) begin
      @(negedge clk);
      model_step(fast);
    end
    tick = 1'b0; fast_set = 1'b0;
    expect_now(req);
  endtask

  task automatic idle(int n, bit fast, string req);
    @(negedge clk);
    fast_set = fast;
    repeat (n) @(negedge clk);
    if (fast) pre = 0;
    fast_set = 1'b0;
    expect_now(req);
  endtask

  task automatic do_reset(string req);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    secs = 0; pre = 0;
    expect_now(req);
  endtask

  task automatic jump_to(int target, string req);
    if (target > secs) run(target - secs, 1'b1, req);
  endtask

  // monitor: compares the design's digits against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [23:0] act;
        it  = sb_q.pop_front();
        act = {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};
        n_checks++;
        if (act !== it.hms) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.hms);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset("R1 reset to midnight");
    run(59, 1'b0, "R2 no advance before sixtieth tick");
    run(1, 1'b0, "R2 advance on sixtieth tick");
    idle(20, 1'b0, "R3 hold without tick");
    run(30, 1'b0, "R2 partial prescale");
    idle(3, 1'b1, "R3 fast_set without tick holds");
    run(59, 1'b0, "R8 prescaler cleared by fast_set");
    run(1, 1'b0, "R8 full sixty ticks after release");
    run(7, 1'b1, "R7 each fast tick steps");
    run(1, 1'b1, "R4 units 9 to tens");
    jump_to(59, "R4 reach 59 s");
    run(1, 1'b1, "R5 seconds rollover carries to minutes");
    jump_to(119, "R7 reach 00:01:59");
    run(60, 1'b0, "R5 normal-mode minute carry");
    jump_to(3599, "R5 reach 00:59:59");
    run(1, 1'b1, "R6 minute rollover into hours");
    jump_to(9 * 3600 + 3599, "R6 reach 09:59:59");
    run(1, 1'b1, "R9 hour units carry into tens");
    jump_to(19 * 3600 + 3599, "R6 reach 19:59:59");
    run(1, 1'b1, "R9 hours 19 to 20");
    jump_to(86399, "R6 reach 23:59:59");
    run(1, 1'b1, "R6 midnight wrap");
    run(5, 1'b1, "R7 steps after wrap");
    do_reset("R1 reset mid-run");
    run(60, 1'b0, "R1 prescaler cleared by reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule